// File: doc/BRIEF.md
# UART Receive Idle Timeout Watchdog

This block sits beside a UART receiver and tells the host when characters have been left waiting in the receive FIFO while the serial line has gone quiet. It counts down in bit-times from a programmed length. It counts only while the FIFO holds data and the receive input is idle. When the count runs out, a sticky timeout flag rises. The host then drains the FIFO even though the interrupt fill level was never reached.

The programmed value is an 8-bit field. The wait it selects is eight bit-times per unit plus a fixed seven bit-times. The counter restarts at full length after every received frame, so a very short setting can expire in the middle of a burst of back-to-back frames. The length is sampled only when the counter reloads. The baud generator, the receiver shifter and the FIFO are outside this block; they supply the tick, the idle flag, the empty flag and the frame-end strobe.

Top module: `uart_rx_idle_watchdog`

## Requirements
- R1: After a reload, the flag rises on the clock edge that takes the N-th qualifying bit tick, where N = toValue*8 + 7 (the value shifted left by three with the three low bits set to one). A value of 0 gives 7, a value of 1 gives 15, and a value of 3 gives 31.
- R2: Reset loads the counter with the default length for a value of 3 (31 bit-times) and clears the flag. With no reload after reset, the first expiry therefore comes on the 31st qualifying tick, whatever toValue holds.
- R3: A bit tick decrements the count only while lineIdle is 1 and fifoEmpty is 0. Ticks with lineIdle 0 do not move the count. Once set, the flag holds until it is cleared.
- R4: A frameEnd pulse reloads the counter and clears the flag. With a value of 0 and a frame end after every 10 ticks, the flag still rises on the 7th tick of each frame.
- R5: While fifoEmpty is 1 the counter is held at its reload length and the flag cannot rise.
- R6: While toEnable is 0 the flag is 0 and the counter is held at its reload length.
- R7: A toClear pulse clears the flag when no expiry happens in the same cycle. The flag does not rise again until a reload has occurred and a full new length has elapsed.
- R8: A change to toValue does not alter a count in progress. It takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bitTick | input | 1 | One-cycle pulse per bit-time |
| lineIdle | input | 1 | Receive input is idle |
| fifoEmpty | input | 1 | Receive FIFO holds no characters |
| frameEnd | input | 1 | One-cycle pulse at the end of a received frame |
| toEnable | input | 1 | Timeout enable |
| toValue | input | 8 | Programmed timeout value |
| toClear | input | 1 | Clears the timeout flag |
| toFlag | output | 1 | Sticky timeout flag |

## Verification
On every cycle, the assertions check the conditions that must pull the flag low or keep it low. These are: a disabled block, a frame end, a clear while the FIFO is empty, an idle clock without a tick, and an empty FIFO. They also check that a set flag holds when nothing clears it. Only the bench scenarios can show the exact tick on which the flag rises for each programmed value. The same holds for the reset-default length, the early expiry within back-to-back short frames, the deferral of a value change to the next reload, and the absence of a second expiry after a clear.

// File: rtl/uart_rxto_pkg.sv
package uart_rxto_pkg;

  // Strobes from the control to the counter datapath.
  typedef struct packed {
    logic load;   // restart at full length
    logic dec;    // take one bit-time off the count
  } cntCmd_t;

endpackage

// File: rtl/rxto_counter.sv
module rxto_counter
  import uart_rxto_pkg::*;
#(
  parameter int VAL_W       = 8,
  parameter int EXT_W       = 3,
  parameter int DEFAULT_VAL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cntCmd_t          cmd,
  input  logic [VAL_W-1:0] toValue,
  output logic             atOne,
  output logic             atZero
);

  localparam int CNT_W = VAL_W + EXT_W;
  localparam logic [VAL_W-1:0] DEF_V = VAL_W'(DEFAULT_VAL);
  localparam logic [CNT_W-1:0] RESET_LEN = {DEF_V, {EXT_W{1'b1}}};

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] reloadLen;

  // value * 2^EXT_W + (2^EXT_W - 1)
  generate
    if (EXT_W > 0) begin : g_ext
      assign reloadLen = {toValue, {EXT_W{1'b1}}};
    end else begin : g_noext
      assign reloadLen = toValue;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= RESET_LEN;
    end else if (cmd.load) begin
      count <= reloadLen;
    end else if (cmd.dec && (count != '0)) begin
      count <= count - CNT_W'(1);
    end
  end

  assign atOne  = (count == CNT_W'(1));
  assign atZero = (count == '0);

endmodule

// File: rtl/rxto_ctrl.sv
module rxto_ctrl
  import uart_rxto_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    bitTick,
  input  logic    lineIdle,
  input  logic    fifoEmpty,
  input  logic    frameEnd,
  input  logic    toEnable,
  input  logic    toClear,
  input  logic    atOne,
  input  logic    atZero,
  output cntCmd_t cmd,
  output logic    toFlag
);

  logic expire;

  always_comb begin
    cmd.load = frameEnd | fifoEmpty | ~toEnable;
    cmd.dec  = ~cmd.load & bitTick & lineIdle & ~atZero;
    expire   = cmd.dec & atOne;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      toFlag <= 1'b0;
    end else if (!toEnable) begin
      toFlag <= 1'b0;
    end else if (expire) begin
      toFlag <= 1'b1;
    end else if (toClear || frameEnd) begin
      toFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_rx_idle_watchdog.sv
module uart_rx_idle_watchdog
  import uart_rxto_pkg::*;
#(
  parameter int VAL_W       = 8,
  parameter int EXT_W       = 3,
  parameter int DEFAULT_VAL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bitTick,
  input  logic             lineIdle,
  input  logic             fifoEmpty,
  input  logic             frameEnd,
  input  logic             toEnable,
  input  logic [VAL_W-1:0] toValue,
  input  logic             toClear,
  output logic             toFlag
);

  cntCmd_t cmd;
  logic    atOne;
  logic    atZero;

  rxto_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bitTick   (bitTick),
    .lineIdle  (lineIdle),
    .fifoEmpty (fifoEmpty),
    .frameEnd  (frameEnd),
    .toEnable  (toEnable),
    .toClear   (toClear),
    .atOne     (atOne),
    .atZero    (atZero),
    .cmd       (cmd),
    .toFlag    (toFlag)
  );

  rxto_counter #(
    .VAL_W       (VAL_W),
    .EXT_W       (EXT_W),
    .DEFAULT_VAL (DEFAULT_VAL)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .toValue (toValue),
    .atOne   (atOne),
    .atZero  (atZero)
  );

endmodule

// File: rtl/rxto_checker.sv
module rxto_checker (
  input logic clk,
  input logic rst_n,
  input logic bitTick,
  input logic fifoEmpty,
  input logic frameEnd,
  input logic toEnable,
  input logic toClear,
  input logic toFlag
);

  a_r6_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    !toEnable |=> !toFlag);

  a_r4_frame_clears: assert property (@(posedge clk) disable iff (!rst_n)
    frameEnd |=> !toFlag);

  a_r7_clear_wins_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (toClear && fifoEmpty) |=> !toFlag);

  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (toFlag && toEnable && !toClear && !frameEnd) |=> toFlag);

  a_r3_no_tick_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!toFlag && !bitTick) |=> !toFlag);

  a_r5_empty_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!toFlag && fifoEmpty) |=> !toFlag);

endmodule

bind uart_rx_idle_watchdog rxto_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bitTick   (bitTick),
  .fifoEmpty (fifoEmpty),
  .frameEnd  (frameEnd),
  .toEnable  (toEnable),
  .toClear   (toClear),
  .toFlag    (toFlag)
);

// File: tb/uart_rx_idle_watchdog_tb.sv
module uart_rx_idle_watchdog_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bitTick = 1'b0;
  logic       lineIdle = 1'b1;
  logic       fifoEmpty = 1'b0;
  logic       frameEnd = 1'b0;
  logic       toEnable = 1'b1;
  logic [7:0] toValue = 8'd0;
  logic       toClear = 1'b0;
  logic       toFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  uart_rx_idle_watchdog u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bitTick   (bitTick),
    .lineIdle  (lineIdle),
    .fifoEmpty (fifoEmpty),
    .frameEnd  (frameEnd),
    .toEnable  (toEnable),
    .toValue   (toValue),
    .toClear   (toClear),
    .toFlag    (toFlag)
  );

  // {value, frame gap in ticks (0 = none), first expiry tick (0 = never)}
  localparam logic [23:0] VEC [7] = '{
    {8'd0, 8'd0,  8'd7},
    {8'd1, 8'd0,  8'd15},
    {8'd3, 8'd0,  8'd31},
    {8'd5, 8'd0,  8'd47},
    {8'd0, 8'd10, 8'd7},
    {8'd1, 8'd10, 8'd0},
    {8'd2, 8'd30, 8'd23}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: toFlag=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic tick(input logic idle);
    @(negedge clk);
    bitTick  = 1'b1;
    lineIdle = idle;
    @(negedge clk);
    bitTick  = 1'b0;
    lineIdle = 1'b1;
  endtask

  task automatic reloadWith(input logic [7:0] v);
    @(negedge clk);
    toValue   = v;
    fifoEmpty = 1'b1;
    toClear   = 1'b1;
    @(negedge clk);
    fifoEmpty = 1'b0;
    toClear   = 1'b0;
  endtask

  task automatic pulseFrame();
    @(negedge clk);
    frameEnd = 1'b1;
    @(negedge clk);
    frameEnd = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: toFlag=%0b expected completion", toFlag);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R2: reset state and default length 31 regardless of toValue = 0
    repeat (3) @(negedge clk);
    chk("R2 reset flag", toFlag, 1'b0);
    rst_n = 1'b1;
    for (int k = 1; k <= 31; k++) begin
      tick(1'b1);
      if (k == 30) chk("R2 default not yet at 30", toFlag, 1'b0);
      if (k == 31) chk("R2 default expiry at 31", toFlag, 1'b1);
    end

    // R1 R4: table walk
    for (int i = 0; i < 7; i++) begin
      automatic int len   = int'(VEC[i][23:16]) * 8 + 7;
      automatic int gap   = int'(VEC[i][15:8]);
      automatic int first = int'(VEC[i][7:0]);
      automatic int since = 0;
      automatic int seen  = 0;
      automatic logic expF = 1'b0;
      reloadWith(VEC[i][23:16]);
      chk("R1 flag low after reload", toFlag, 1'b0);
      for (int t = 1; t <= 50; t++) begin
        tick(1'b1);
        since++;
        if (since == len) expF = 1'b1;
        if (toFlag && seen == 0) seen = t;
        chk(gap != 0 ? "R4 frame tick" : "R1 tick", toFlag, expF);
        if (gap != 0 && (t % gap) == 0) begin
          pulseFrame();
          since = 0;
          expF  = 1'b0;
          chk("R4 frame end clears", toFlag, 1'b0);
        end
      end
      checks++;
      if (seen != first) begin
        fails++;
        $display("FAIL R1 first expiry vector %0d: tick=%0d expected %0d", i, seen, first);
      end
    end

    // R3: non-idle ticks are ignored
    reloadWith(8'd0);
    for (int k = 0; k < 5; k++) tick(1'b1);
    for (int k = 0; k < 12; k++) tick(1'b0);
    tick(1'b1);
    chk("R3 busy ticks ignored at 6", toFlag, 1'b0);
    tick(1'b1);
    chk("R3 expiry at 7th idle tick", toFlag, 1'b1);
    for (int k = 0; k < 4; k++) tick(1'b1);
    chk("R3 flag sticky", toFlag, 1'b1);

    // R7: clear, then no new expiry without a reload
    @(negedge clk); toClear = 1'b1;
    @(negedge clk); toClear = 1'b0;
    chk("R7 clear drops flag", toFlag, 1'b0);
    for (int k = 0; k < 20; k++) tick(1'b1);
    chk("R7 no refire without reload", toFlag, 1'b0);

    // R5: empty FIFO holds counter at length
    @(negedge clk); toValue = 8'd0; fifoEmpty = 1'b1;
    for (int k = 0; k < 20; k++) tick(1'b1);
    chk("R5 no expiry while empty", toFlag, 1'b0);
    @(negedge clk); fifoEmpty = 1'b0;
    for (int k = 0; k < 6; k++) tick(1'b1);
    chk("R5 full length after empty at 6", toFlag, 1'b0);
    tick(1'b1);
    chk("R5 full length after empty at 7", toFlag, 1'b1);

    // R6: disabled never fires, and disable drops the flag
    @(negedge clk); toEnable = 1'b0;
    @(negedge clk);
    chk("R6 disable drops flag", toFlag, 1'b0);
    for (int k = 0; k < 20; k++) tick(1'b1);
    chk("R6 disabled no expiry", toFlag, 1'b0);
    @(negedge clk); toEnable = 1'b1;
    for (int k = 0; k < 6; k++) tick(1'b1);
    chk("R6 reload while disabled at 6", toFlag, 1'b0);
    tick(1'b1);
    chk("R6 reload while disabled at 7", toFlag, 1'b1);

    // R8: new value waits for next reload
    reloadWith(8'd0);
    @(negedge clk); toValue = 8'd3;
    for (int k = 0; k < 6; k++) tick(1'b1);
    chk("R8 old length still running at 6", toFlag, 1'b0);
    tick(1'b1);
    chk("R8 old length expiry at 7", toFlag, 1'b1);
    pulseFrame();
    for (int k = 0; k < 30; k++) tick(1'b1);
    chk("R8 new length not yet at 30", toFlag, 1'b0);
    tick(1'b1);
    chk("R8 new length expiry at 31", toFlag, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule